// File: doc/BRIEF.md
# PCI Power-State Wake Controller

This block handles power management for one USB host-controller function that sits on PCI. Software uses a small configuration read/write port to choose one of four device power states. The block holds that choice in a control/status word. From it the block derives an enable for the internal 48 MHz clock gate, an enable for the USB transceivers, and an enable for the asynchronous resume path.

A wake event is either an upstream resume or a connect-status change on a port. A connect-status change covers both an attach and a detach. The event is captured by an asynchronous set latch, so it is caught even while the 48 MHz clock is stopped. The latch output is synchronised into the configuration clock domain and sets a sticky wake-status flag. While wake is enabled, that flag pulls the active-low wake output low.

A strap input can hide the whole capability. When it is high, the capability words, the capability pointer and the "capability list present" status bit all read as zero, and all power-management function is held off. Removing power entirely is modelled by the reset, which is the only way back to the full-power state.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset the block is in the following state. The power state is D0, wake enable is 0 and wake status is 0. `pme_n` is 1, `clk48_en` is 1 and `xcvr_en` is 1. `async_resume_en` and `resume_drive` are 0.
- R2: The control/status word is at dword index CAP_DW+1, and its fields are as follows. Bits [1:0] hold the power state, where 00 is D0, 01 is D1, 10 is D2 and 11 is D3hot. Bit 8 is wake enable. Bit 15 is wake status. Writes to bits [1:0] and bit 8 read back unchanged.
- R3: In D0 and D1, `clk48_en` and `xcvr_en` are both 1 from the clock edge after the state is written.
- R4: In D2, `clk48_en` is 0 and `xcvr_en` is 1. In D3hot both are 0. Each change takes effect at the first clock edge after the write.
- R5: Leaving D2 or D3hot for D0 or D1 raises `clk48_en` at the first edge after the write. A transceiver that was off is enabled exactly SETTLE cycles after `clk48_en` rises, and never before it.
- R6: A wake event is a pulse on `resume_det` or `conn_chg` while wake enable is 1. Its effect is counted from the first rising clock edge after the event. `pme_n` goes low and status bit 15 reads 1 after the third such edge, and not earlier.
- R7: A wake event while wake enable is 0 is ignored. `pme_n` stays 1 and status bit 15 stays 0.
- R8: A write with bit 15 set clears wake status, and `pme_n` returns to 1 after that write's clock edge. A write with bit 15 clear leaves wake status unchanged.
- R9: `async_resume_en` is 1 only when wake enable is 1 and the state is D2 or D3hot. In that condition a wake event raises `resume_drive` without any clock edge.
- R10: When `strap_hide` is 0, the following reads apply. Dword 13 bits [7:0] read CAP_DW*4. Dword 1 bit 20 reads 1. Dword CAP_DW reads capability ID 0x01 in [7:0], next pointer 0 in [15:8] and 0x7E02 in [31:16].
- R11: When `strap_hide` is 1, every read returns 0 and writes to the control/status word are ignored. The outputs hold their D0 values (`pme_n` 1, `clk48_en` 1, `xcvr_en` 1), and wake events do not assert `pme_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset (power removal) |
| strap_hide | input | 1 | 1 hides and disables the capability |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | ADDR_W | Dword index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| resume_det | input | 1 | Upstream resume detected (asynchronous) |
| conn_chg | input | 1 | Port connect-status change (asynchronous) |
| clk48_en | output | 1 | Internal 48 MHz clock-gate enable |
| xcvr_en | output | 1 | USB transceiver enable |
| async_resume_en | output | 1 | Asynchronous resume path enabled |
| resume_drive | output | 1 | Request to drive USB resume signalling |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The bench builds the block with SETTLE = 3, CAP_DW = 16 and ADDR_W = 6. With a short settle window, the bench can pin the exact cycle in which the transceiver comes back relative to the clock gate. CAP_DW = 16 puts the capability at byte 0x40 and the pointer value at 0x40. The bench places wake pulses between clock edges, so the two synchroniser stages and the status flop give a known third-edge arrival. It also observes the clockless path of `resume_drive` directly.

// File: rtl/pm_wake_pkg.sv
// Shared types for the power-state wake controller.
// Assumes a 32-bit configuration data path.
package pm_wake_pkg;
    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pwr_state_e;

    localparam int          CFG_DW    = 32;
    localparam logic [7:0]  CAP_ID_PM = 8'h01;
    // Capability word upper half: version 2, D1/D2 supported, wake from D0..D3hot.
    localparam logic [15:0] PM_CAPS   = {1'b0, 4'b1111, 1'b1, 1'b1, 6'b0, 3'b010};
endpackage

// File: rtl/pm_wake_capture.sv
// Wake capture: an asynchronous set latch catches a wake event with no clock
// running, a synchroniser brings it into clk, and an edge detector emits
// one pulse per capture. Assumes SYNC_STAGES >= 2 and wake inputs glitch-free.
module pm_wake_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,         // wake enable
    input  logic wake_evt,    // resume or connect change, asynchronous
    input  logic clr,         // synchronous clear of the latch
    output logic latched_o,
    output logic wake_pulse_o
);
    logic                   set_async;
    logic                   latch_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    assign set_async = arm & wake_evt;

    // Latch: set asynchronously by an armed event, cleared on a clock edge.
    always_ff @(posedge clk or posedge set_async) begin
        if (set_async)
            latch_q <= 1'b1;
        else if (!rst_n || clr)
            latch_q <= 1'b0;
    end

    // Synchroniser chain carrying the latch into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], latch_q};
    end

    // Previous synchronised value for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign latched_o    = latch_q;
    assign wake_pulse_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/pm_clk_seq.sv
// Clock-gate and transceiver sequencer. Derives both enables from the power
// state and, on return to full power, holds the transceiver off until the
// clock has run for SETTLE cycles. Assumes SETTLE >= 1.
module pm_clk_seq
    import pm_wake_pkg::*;
#(
    parameter int SETTLE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e state,
    output logic       clk48_en,
    output logic       xcvr_en
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    logic             want_clk;
    logic             want_xcvr;
    logic [CNT_W-1:0] cnt_q;

    assign want_clk  = (state == PS_D0) || (state == PS_D1);
    assign want_xcvr = (state != PS_D3HOT);

    // Settle counter: loaded when the clock gate opens, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (want_clk && !clk48_en)
            cnt_q <= CNT_W'(SETTLE - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Enable registers: clock follows state, transceiver waits for settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk48_en <= 1'b1;
            xcvr_en  <= 1'b1;
        end else begin
            clk48_en <= want_clk;
            xcvr_en  <= want_xcvr &&
                        (xcvr_en || !want_clk || (clk48_en && cnt_q == '0));
        end
    end
endmodule

// File: rtl/pm_cfg_regs.sv
// Configuration registers of the capability: power state, wake enable and
// sticky wake status, plus the read decode of pointer, status bit and
// capability header. Assumes single-dword accesses without byte enables.
module pm_cfg_regs
    import pm_wake_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CAP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hide,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              wake_pulse,
    output pwr_state_e        state_o,
    output logic              pme_en_o,
    output logic              pme_sts_o,
    output logic              sts_clr_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PTR    = ADDR_W'(13);
    localparam logic [ADDR_W-1:0] A_CAP    = ADDR_W'(CAP_DW);
    localparam logic [ADDR_W-1:0] A_CSR    = ADDR_W'(CAP_DW + 1);
    localparam logic [7:0]        PTR_VAL  = 8'(CAP_DW * 4);

    logic wr_csr;
    logic unused_wdata;

    assign wr_csr       = cfg_wr && !hide && (cfg_addr == A_CSR);
    assign sts_clr_o    = wr_csr && cfg_wdata[15];
    assign unused_wdata = ^{cfg_wdata[31:16], cfg_wdata[14:9], cfg_wdata[7:2]};

    // State, enable and sticky status; held at reset values while hidden.
    always_ff @(posedge clk) begin
        if (!rst_n || hide) begin
            state_o   <= PS_D0;
            pme_en_o  <= 1'b0;
            pme_sts_o <= 1'b0;
        end else begin
            if (wr_csr) begin
                state_o  <= pwr_state_e'(cfg_wdata[1:0]);
                pme_en_o <= cfg_wdata[8];
            end
            if (wake_pulse)
                pme_sts_o <= 1'b1;
            else if (sts_clr_o)
                pme_sts_o <= 1'b0;
        end
    end

    // Read decode; everything reads zero while the capability is hidden.
    always_comb begin
        cfg_rdata = '0;
        if (!hide) begin
            unique case (cfg_addr)
                A_STATUS: cfg_rdata[20]   = 1'b1;
                A_PTR:    cfg_rdata[7:0]  = PTR_VAL;
                A_CAP:    cfg_rdata       = {PM_CAPS, 8'h00, CAP_ID_PM};
                A_CSR:    cfg_rdata       = {16'h0, pme_sts_o, 6'h0, pme_en_o,
                                             6'h0, state_o};
                default:  cfg_rdata       = '0;
            endcase
        end
    end
endmodule

// File: rtl/pm_wake_ctrl.sv
// Top of the power-state wake controller: joins register file, wake capture
// and clock sequencer, and forms the wake and resume outputs.
// Assumes the strap is static except across a reset-like transition.
module pm_wake_ctrl
    import pm_wake_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int CAP_DW      = 16,
    parameter int SETTLE      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hide,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              resume_det,
    input  logic              conn_chg,
    output logic              clk48_en,
    output logic              xcvr_en,
    output logic              async_resume_en,
    output logic              resume_drive,
    output logic              pme_n
);
    pwr_state_e state_q;
    logic       pme_en_q;
    logic       pme_sts_q;
    logic       sts_clr;
    logic       wake_pulse;
    logic       wake_latched;

    pm_cfg_regs #(.ADDR_W(ADDR_W), .CAP_DW(CAP_DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hide(strap_hide),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wake_pulse(wake_pulse),
        .state_o(state_q), .pme_en_o(pme_en_q), .pme_sts_o(pme_sts_q),
        .sts_clr_o(sts_clr)
    );

    pm_wake_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk(clk), .rst_n(rst_n), .arm(pme_en_q),
        .wake_evt(resume_det | conn_chg), .clr(sts_clr | ~pme_en_q),
        .latched_o(wake_latched), .wake_pulse_o(wake_pulse)
    );

    pm_clk_seq #(.SETTLE(SETTLE)) u_seq (
        .clk(clk), .rst_n(rst_n), .state(state_q),
        .clk48_en(clk48_en), .xcvr_en(xcvr_en)
    );

    assign async_resume_en = pme_en_q &&
                             ((state_q == PS_D2) || (state_q == PS_D3HOT));
    assign resume_drive    = wake_latched & async_resume_en;
    assign pme_n           = ~(pme_sts_q & pme_en_q);
endmodule

// File: rtl/pm_wake_ctrl_chk.sv
// Checker for the wake controller, bound to the top. Observes ports and the
// register outputs; drives nothing.
module pm_wake_ctrl_chk
    import pm_wake_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        strap_hide,
    input logic [31:0] cfg_rdata,
    input logic        clk48_en,
    input logic        xcvr_en,
    input logic        async_resume_en,
    input logic        resume_drive,
    input logic        pme_n,
    input pwr_state_e  state_q,
    input logic        pme_en_q
);
    // R7: the wake output is only asserted while wake is enabled.
    a_r7_pme_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_n |-> pme_en_q);

    // R11: a hidden capability reads as zero everywhere.
    a_r11_hidden_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        strap_hide |-> (cfg_rdata == 32'h0));

    // R5: the transceiver never comes up in the same cycle as the clock.
    a_r5_clock_before_xcvr: assert property (@(posedge clk) disable iff (!rst_n)
        (clk48_en && $rose(xcvr_en)) |-> $past(clk48_en));

    // R4: a settled D3hot has both clock and transceiver off.
    a_r4_d3hot_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_D3HOT && $past(state_q) == PS_D3HOT) |-> (!clk48_en && !xcvr_en));

    // R9: resume is only driven while the asynchronous path is enabled.
    a_r9_resume_gated: assert property (@(posedge clk) disable iff (!rst_n)
        resume_drive |-> async_resume_en);

    // R3: a settled D0 has the clock running.
    a_r3_d0_clock_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_D0 && $past(state_q) == PS_D0) |-> clk48_en);
endmodule

bind pm_wake_ctrl pm_wake_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .strap_hide(strap_hide), .cfg_rdata(cfg_rdata),
    .clk48_en(clk48_en), .xcvr_en(xcvr_en), .async_resume_en(async_resume_en),
    .resume_drive(resume_drive), .pme_n(pme_n), .state_q(state_q),
    .pme_en_q(pme_en_q)
);

// File: tb/pm_wake_ctrl_tb_top.sv
// Self-checking bench for pm_wake_ctrl.
module pm_wake_ctrl_tb_top;
    localparam int ADDR_W = 6;
    localparam int CAP_DW = 16;
    localparam int SETTLE = 3;
    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CAP_DW + 1);

    // Vector: {pme_en, state[1:0], exp_clk, exp_xcvr, exp_async}
    localparam logic [5:0] VEC [8] = '{
        {1'b0, 2'b01, 1'b1, 1'b1, 1'b0},
        {1'b0, 2'b10, 1'b0, 1'b1, 1'b0},
        {1'b1, 2'b10, 1'b0, 1'b1, 1'b1},
        {1'b1, 2'b11, 1'b0, 1'b0, 1'b1},
        {1'b0, 2'b11, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'b00, 1'b1, 1'b1, 1'b0},
        {1'b1, 2'b01, 1'b1, 1'b1, 1'b0},
        {1'b0, 2'b00, 1'b1, 1'b1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap_hide = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              resume_det = 1'b0;
    logic              conn_chg = 1'b0;
    logic              clk48_en, xcvr_en, async_resume_en, resume_drive, pme_n;
    int                n_checks = 0;
    int                n_fails = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    pm_wake_ctrl #(.ADDR_W(ADDR_W), .CAP_DW(CAP_DW), .SETTLE(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_hide(strap_hide), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .resume_det(resume_det), .conn_chg(conn_chg), .clk48_en(clk48_en),
        .xcvr_en(xcvr_en), .async_resume_en(async_resume_en),
        .resume_drive(resume_drive), .pme_n(pme_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                             input string req);
        cfg_addr = a;
        #1;
        check(cfg_rdata === e, req, cfg_rdata, e);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        // R1: reset state
        cfg_check(A_CSR, 32'h0, "R1 csr");
        check({pme_n, clk48_en, xcvr_en, async_resume_en, resume_drive} === 5'b11100,
              "R1 outputs", {pme_n, clk48_en, xcvr_en, async_resume_en, resume_drive}, 5'b11100);

        // R10: capability visible
        cfg_check(ADDR_W'(13), 32'h40, "R10 pointer");
        cfg_check(ADDR_W'(1), 32'h0010_0000, "R10 status bit");
        cfg_check(ADDR_W'(CAP_DW), 32'h7E02_0001, "R10 header");

        // R2 R3 R4 R9: table walk
        for (int i = 0; i < 8; i++) begin
            logic [31:0] wv;
            wv = {23'h0, VEC[i][5], 6'h0, VEC[i][4:3]};
            cfg_write(A_CSR, wv);
            cycles(SETTLE + 2);
            cfg_check(A_CSR, wv, "R2 readback");
            check(clk48_en === VEC[i][2], "R3 R4 clk48_en", 32'(clk48_en), 32'(VEC[i][2]));
            check(xcvr_en === VEC[i][1], "R3 R4 xcvr_en", 32'(xcvr_en), 32'(VEC[i][1]));
            check(async_resume_en === VEC[i][0], "R9 async_resume_en",
                  32'(async_resume_en), 32'(VEC[i][0]));
        end

        // R5: D3hot -> D0 sequencing
        cfg_write(A_CSR, 32'h3);
        cycles(2);
        cfg_write(A_CSR, 32'h0);
        check(clk48_en === 1'b0, "R5 clk before edge", 32'(clk48_en), 0);
        cycles(1);
        check(clk48_en === 1'b1 && xcvr_en === 1'b0, "R5 clk first",
              {clk48_en, xcvr_en}, 2'b10);
        cycles(SETTLE - 1);
        check(xcvr_en === 1'b0, "R5 xcvr still off", 32'(xcvr_en), 0);
        cycles(1);
        check(xcvr_en === 1'b1, "R5 xcvr on after settle", 32'(xcvr_en), 1);

        // R6: resume wake timing with enable set
        cfg_write(A_CSR, 32'h100);
        resume_det = 1'b1;
        cycles(1);
        resume_det = 1'b0;
        cycles(1);
        check(pme_n === 1'b1, "R6 not before third edge", 32'(pme_n), 1);
        cycles(1);
        check(pme_n === 1'b0, "R6 pme asserted", 32'(pme_n), 0);
        cfg_check(A_CSR, 32'h8100, "R6 status bit");

        // R8: write without bit 15 keeps, with bit 15 clears
        cfg_write(A_CSR, 32'h100);
        check(pme_n === 1'b0, "R8 kept", 32'(pme_n), 0);
        cfg_write(A_CSR, 32'h8100);
        check(pme_n === 1'b1, "R8 cleared", 32'(pme_n), 1);
        cycles(4);
        cfg_check(A_CSR, 32'h100, "R8 status stays clear");

        // R7: event ignored while disabled
        cfg_write(A_CSR, 32'h0);
        conn_chg = 1'b1;
        cycles(1);
        conn_chg = 1'b0;
        cycles(5);
        check(pme_n === 1'b1, "R7 pme ignored", 32'(pme_n), 1);
        cfg_check(A_CSR, 32'h0, "R7 status ignored");

        // R9: clockless resume drive in D3hot, R6 for connect change
        cfg_write(A_CSR, 32'h103);
        cycles(2);
        check(resume_drive === 1'b0, "R9 idle", 32'(resume_drive), 0);
        conn_chg = 1'b1;
        #1;
        check(resume_drive === 1'b1, "R9 async drive", 32'(resume_drive), 1);
        cycles(1);
        conn_chg = 1'b0;
        cycles(3);
        check(pme_n === 1'b0, "R6 connect change wake", 32'(pme_n), 0);
        cfg_write(A_CSR, 32'h8100);
        check(resume_drive === 1'b0 && pme_n === 1'b1, "R8 R9 cleared",
              {resume_drive, pme_n}, 2'b01);
        cycles(SETTLE + 2);

        // R11: hidden capability
        strap_hide = 1'b1;
        cycles(1);
        cfg_check(ADDR_W'(13), 32'h0, "R11 pointer");
        cfg_check(ADDR_W'(1), 32'h0, "R11 status bit");
        cfg_check(ADDR_W'(CAP_DW), 32'h0, "R11 header");
        cfg_check(A_CSR, 32'h0, "R11 csr");
        cfg_write(A_CSR, 32'h103);
        cycles(2);
        check(clk48_en === 1'b1 && xcvr_en === 1'b1, "R11 write ignored",
              {clk48_en, xcvr_en}, 2'b11);
        resume_det = 1'b1;
        cycles(1);
        resume_det = 1'b0;
        cycles(4);
        check(pme_n === 1'b1, "R11 no wake", 32'(pme_n), 1);
        strap_hide = 1'b0;
        cycles(1);
        cfg_check(A_CSR, 32'h0, "R11 state back at D0");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule